// File: doc/BRIEF.md
# Transceiver Power-Up Reset Sequencer

This block drives two control lines of an external USB transceiver: a reset line and a stop line. After a load event the transceiver is first held in reset for a fixed number of clock cycles. Reset is then released while the stop line stays high for a second fixed interval. After that, both lines go low and the block rests.

A load event is either the synchronous system reset or a one-cycle (or longer) strobe on the trigger input. A load event restarts the sequence from its first phase, whatever phase the block is in. Both interval lengths are parameters given in clock cycles.

Top module: `phy_rst_seq`

## Requirements
- R1: While `rst` is high, the cycle after each clock edge shows `phy_reset` = 1 and `phy_stop` = 1.
- R2: After the last clock edge at which `rst` or `trigger` was high, `phy_reset` stays 1 for exactly RESET_CYCLES cycles and then drops to 0.
- R3: `phy_stop` is 1 throughout the reset phase.
- R4: `phy_stop` stays 1 for exactly STOP_CYCLES cycles after `phy_reset` falls, then drops to 0.
- R5: A `trigger` sampled high in any phase restarts the sequence from the reset phase on the next cycle.
- R6: Once both outputs are 0, they stay 0 until `rst` or `trigger` is sampled high.
- R7: A `trigger` held high for several cycles keeps the sequence at its start, and the interval counts from the last cycle in which it was high.
- R8: `phy_reset` is never 1 while `phy_stop` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high; loads the sequence |
| trigger | input | 1 | Restart strobe, active high |
| phy_reset | output | 1 | Transceiver reset, active high |
| phy_stop | output | 1 | Transceiver stop, active high |

## Verification
The assertions assume that `rst` is applied before the outputs mean anything, and they only start to constrain the outputs after the first load event. They also assume that `rst` and `trigger` are stable around the sampling edge. The stimulus changes both inputs only on the falling clock edge. It applies `rst` first. It then moves `trigger` through each phase, the idle state and multi-cycle pulses, so every load event is one the assertions can count from.

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
  parameter int RESET_CYCLES = 120,
  parameter int STOP_CYCLES  = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  output logic phy_reset,
  output logic phy_stop
);
  localparam int LONGEST = (RESET_CYCLES > STOP_CYCLES) ? RESET_CYCLES : STOP_CYCLES;
  localparam int CW      = $clog2(LONGEST + 1);

  typedef enum logic [1:0] {PH_HOLD, PH_QUIET, PH_IDLE} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          load;

  assign load = rst | trigger;

  always_ff @(posedge clk) begin
    if (load) begin
      phase <= PH_HOLD;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_HOLD:
          if (cnt == CW'(RESET_CYCLES - 1)) begin
            phase <= PH_QUIET;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        PH_QUIET:
          if (cnt == CW'(STOP_CYCLES - 1)) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        default: cnt <= '0;
      endcase
    end
  end

  assign phy_reset = (phase == PH_HOLD);
  assign phy_stop  = (phase != PH_IDLE);
endmodule

module phy_rst_seq_chk #(
  parameter int RESET_CYCLES = 120,
  parameter int STOP_CYCLES  = 120
) (
  input logic clk,
  input logic rst,
  input logic trigger,
  input logic phy_reset,
  input logic phy_stop
);
  localparam int TOTAL = RESET_CYCLES + STOP_CYCLES;

  int   since;
  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (rst || trigger) begin
      since <= 0;
      armed <= 1'b1;
    end else if (since < TOTAL) since <= since + 1;
  end

  AST_RESET_WITH_STOP: assert property (@(posedge clk) disable iff (rst) phy_reset |-> phy_stop); // R8
  AST_RESET_WINDOW:    assert property (@(posedge clk) disable iff (rst) armed |-> (phy_reset == (since < RESET_CYCLES))); // R2
  AST_STOP_WINDOW:     assert property (@(posedge clk) disable iff (rst) armed |-> (phy_stop == (since < TOTAL))); // R4
  AST_TRIG_RESTART:    assert property (@(posedge clk) disable iff (rst) trigger |=> (phy_reset && phy_stop)); // R5
  AST_IDLE_HOLDS:      assert property (@(posedge clk) disable iff (rst) (armed && !phy_stop && !trigger) |=> (!phy_stop && !phy_reset)); // R6
endmodule

bind phy_rst_seq phy_rst_seq_chk #(.RESET_CYCLES(RESET_CYCLES), .STOP_CYCLES(STOP_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .trigger(trigger), .phy_reset(phy_reset), .phy_stop(phy_stop));

// File: tb/phy_rst_seq_tb.sv
module phy_rst_seq_tb_top;
  localparam int RC = 120;
  localparam int SC = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trigger = 1'b0;
  logic phy_reset, phy_stop;
  int checks = 0;
  int errors = 0;
  int ref_age = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  phy_rst_seq #(.RESET_CYCLES(RC), .STOP_CYCLES(SC)) dut_i (
    .clk(clk), .rst(rst), .trigger(trigger), .phy_reset(phy_reset), .phy_stop(phy_stop));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst || trigger) ref_age <= 0;
    else if (ref_age < RC + SC) ref_age <= ref_age + 1;
  end

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // every-cycle comparison against the reference model
  always @(negedge clk) begin
    check(phy_reset, ref_age < RC, "R2");
    check(phy_stop, ref_age < RC + SC, (ref_age >= RC + SC) ? "R6" : "R4");
    check(!(phy_reset && !phy_stop), 1'b1, "R8");
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    check(phy_reset, 1'b1, "R1");
    check(phy_stop, 1'b1, "R1");
    rst = 1'b0;
    wait_n(RC - 1);
    check(phy_reset, 1'b1, "R2");
    check(phy_stop, 1'b1, "R3");
    wait_n(1);
    check(phy_reset, 1'b0, "R2");
    check(phy_stop, 1'b1, "R4");
    wait_n(SC - 1);
    check(phy_stop, 1'b1, "R4");
    wait_n(1);
    check(phy_stop, 1'b0, "R4");
    wait_n(40);
    check(phy_stop, 1'b0, "R6");
    check(phy_reset, 1'b0, "R6");
    // restart from idle
    trigger = 1'b1; wait_n(1); trigger = 1'b0;
    check(phy_reset, 1'b1, "R5");
    wait_n(50);
    // restart mid reset phase
    trigger = 1'b1; wait_n(1); trigger = 1'b0;
    wait_n(RC - 1);
    check(phy_reset, 1'b1, "R5");
    wait_n(30);
    // restart mid stop phase
    check(phy_reset, 1'b0, "R5");
    trigger = 1'b1; wait_n(1); trigger = 1'b0;
    check(phy_reset, 1'b1, "R5");
    check(phy_stop, 1'b1, "R3");
    wait_n(20);
    // held trigger
    trigger = 1'b1; wait_n(6); trigger = 1'b0;
    wait_n(RC - 1);
    check(phy_reset, 1'b1, "R7");
    wait_n(1);
    check(phy_reset, 1'b0, "R7");
    wait_n(60);
    // system reset mid stop phase
    rst = 1'b1; wait_n(2);
    check(phy_reset, 1'b1, "R1");
    rst = 1'b0;
    wait_n(RC + SC + 30);
    check(phy_stop, 1'b0, "R6");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule